// File: doc/BRIEF.md
# Cold and Warm Reset Sequencer

This block drives the two active-low reset lines of a processor from a power-good indication and a warm-reset request. When power is reported stable, it holds the cold reset low for a long, parameterised count of master clock cycles. It then releases the cold reset and keeps the warm reset low for a shorter tail. Both lines change only on the master clock edge. A one-cycle strobe fires a fixed number of cycles before the cold reset is released, while cold reset is still low. It is meant to latch the clock-ratio strap with setup and hold margin.

Once both lines are released, a done flag rises. A rising edge on the warm-reset request then pulses only the warm reset for the tail length, and the cold reset stays high. A warm request that arrives while a cold sequence or its tail is running is absorbed. If power-good falls at any time, all outputs drop in the same cycle and the complete sequence starts over when power returns.

Top module: `rstseq_top`

## Requirements
- R1: While rst_ni is low, cold_rst_no, warm_rst_no, strap_stb_o and done_o are all 0, whatever pwr_good_i is.
- R2: After pwr_good_i rises, cold_rst_no stays 0 for exactly COLD_CYC + SYNC_STAGES clock cycles and then goes to 1. The default COLD_CYC is 64001 and the default SYNC_STAGES is 2.
- R3: After cold_rst_no rises, warm_rst_no stays 0 for exactly WARM_CYC cycles (default 17). warm_rst_no is never 1 while cold_rst_no is 0.
- R4: strap_stb_o is a single-cycle pulse that occurs exactly once per cold sequence. It rises exactly STRAP_LEAD clock edges before cold_rst_no rises, while cold_rst_no is still 0.
- R5: done_o is 1 only while both resets are 1. It rises in the same cycle as warm_rst_no at the end of a sequence.
- R6: While done_o is 1, a rising edge of warm_req_i drives warm_rst_no to 0 from the third clock edge after the rise. It stays 0 for exactly WARM_CYC cycles. During this pulse cold_rst_no stays 1 and strap_stb_o stays 0.
- R7: The warm request is edge-triggered. Holding warm_req_i high gives exactly one warm-only pulse.
- R8: A warm request during the cold hold or the warm tail changes neither interval. It causes no extra warm pulse after done_o rises.
- R9: When pwr_good_i is 0, cold_rst_no, warm_rst_no and done_o are 0 in the same cycle. When pwr_good_i returns, the full R2 to R5 sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| pwr_good_i | input | 1 | Supplies stable, high active |
| warm_req_i | input | 1 | Warm-reset request, edge-triggered |
| cold_rst_no | output | 1 | Cold reset, active low |
| warm_rst_no | output | 1 | Warm reset, active low |
| strap_stb_o | output | 1 | One-cycle strap capture strobe |
| done_o | output | 1 | Both resets released |

## Verification
Power-up sequences are run with several power-off lengths. Each is run with no request, a request inside the cold hold, a request inside the warm tail, and a request spanning the tail end. Exact interval counts distinguish an absorbed request from one that shortens, stretches or re-triggers a phase. Warm-only pulses with a short and a held request separate edge from level triggering. Power loss is tried both during run and in mid-sequence, which shows that gating is immediate and that the restart runs the full length.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;
  typedef enum logic [1:0] {
    ST_COLD  = 2'd0,
    ST_TAIL  = 2'd1,
    ST_RUN   = 2'd2,
    ST_WONLY = 2'd3
  } seq_st_e;
endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) ff_q <= '0;
        else          ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) ff_q <= '0;
        else          ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rstseq_cnt.sv
`timescale 1ns/1ps
module rstseq_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int COLD_CYC    = 64001,
  parameter int WARM_CYC    = 17,
  parameter int STRAP_LEAD  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic warm_req_i,
  output logic cold_rst_no,
  output logic warm_rst_no,
  output logic strap_stb_o,
  output logic done_o
);
  localparam int MAX_CYC = (COLD_CYC > WARM_CYC) ? COLD_CYC : WARM_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] COLD_LAST = CNT_W'(COLD_CYC - 1);
  localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_CYC - 1);
  localparam logic [CNT_W-1:0] STB_AT    = CNT_W'(COLD_CYC - 1 - STRAP_LEAD);

  seq_st_e          st_q, st_d;
  logic             pg_arst_n, pwr_ok, req_s, req_d_q, req_rise;
  logic             cnt_clr, cnt_en, stb_q;
  logic [CNT_W-1:0] cnt;

  // power loss clears the synchronizer at once
  assign pg_arst_n = rst_ni & pwr_good_i;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
    .clk_i  (clk_i),
    .arst_ni(pg_arst_n),
    .d_i    (1'b1),
    .q_o    (pwr_ok)
  );

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .d_i    (warm_req_i),
    .q_o    (req_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_d_q <= 1'b0;
    else         req_d_q <= req_s;
  end
  assign req_rise = req_s & ~req_d_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_COLD:  if (pwr_ok && cnt == COLD_LAST) st_d = ST_TAIL;
      ST_TAIL:  if (!pwr_ok) st_d = ST_COLD;
                else if (cnt == WARM_LAST) st_d = ST_RUN;
      ST_RUN:   if (!pwr_ok) st_d = ST_COLD;
                else if (req_rise) st_d = ST_WONLY;
      ST_WONLY: if (!pwr_ok) st_d = ST_COLD;
                else if (cnt == WARM_LAST) st_d = ST_RUN;
      default:  st_d = ST_COLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_COLD;
    else         st_q <= st_d;
  end

  assign cnt_clr = (st_d != st_q) || (st_q == ST_COLD && !pwr_ok);
  assign cnt_en  = (st_q != ST_RUN);

  rstseq_cnt #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= (st_q == ST_COLD) && pwr_ok && (cnt == STB_AT);
  end

  assign cold_rst_no = (st_q != ST_COLD) & pwr_good_i;
  assign warm_rst_no = (st_q == ST_RUN) & pwr_good_i;
  assign done_o      = (st_q == ST_RUN) & pwr_good_i;
  assign strap_stb_o = stb_q & pwr_good_i;
endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ns/1ps
module rstseq_chk #(
  parameter int COLD_CYC = 64001,
  parameter int WARM_CYC = 17
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_good_i,
  input logic cold_rst_no,
  input logic warm_rst_no,
  input logic strap_stb_o,
  input logic done_o
);
  logic [31:0] cold_lo_q, warm_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cold_lo_q <= '0;
      warm_lo_q <= '0;
    end else begin
      cold_lo_q <= (!cold_rst_no && pwr_good_i) ? cold_lo_q + 1 : '0;
      warm_lo_q <= (!warm_rst_no && pwr_good_i) ? warm_lo_q + 1 : '0;
    end
  end

  p_cold_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cold_rst_no) |-> cold_lo_q >= COLD_CYC);
  p_warm_tail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warm_rst_no) |-> warm_lo_q >= WARM_CYC);
  p_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_rst_no |-> !warm_rst_no);
  p_stb_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_stb_o |=> !strap_stb_o);
  p_stb_in_cold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_stb_o |-> !cold_rst_no);
  p_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cold_rst_no && warm_rst_no));
  p_pwr_loss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !done_o);
endmodule

bind rstseq_top rstseq_chk #(.COLD_CYC(COLD_CYC), .WARM_CYC(WARM_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_good_i (pwr_good_i),
  .cold_rst_no(cold_rst_no),
  .warm_rst_no(warm_rst_no),
  .strap_stb_o(strap_stb_o),
  .done_o     (done_o)
);

// File: tb/rstseq_top_test.sv
`timescale 1ns/1ps
module rstseq_top_test;
  localparam int C = 40;
  localparam int W = 6;
  localparam int L = 4;
  localparam int NV = 4;

  // {power-off cycles, request start cycle, request length}
  localparam logic [47:0] VECS [NV] = '{
    {16'd2, 16'd0,     16'd0},
    {16'd5, 16'd10,    16'd3},
    {16'd1, 16'(C+3),  16'd2},
    {16'd8, 16'd20,    16'd30}
  };

  logic clk = 1'b0, rst_ni = 1'b0, pwr_good = 1'b1, warm_req = 1'b0;
  logic cold_n, warm_n, stb, done;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  rstseq_top #(.COLD_CYC(C), .WARM_CYC(W), .STRAP_LEAD(L), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good), .warm_req_i(warm_req),
    .cold_rst_no(cold_n), .warm_rst_no(warm_n), .strap_stb_o(stb), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input int off, input int req_at, input int req_len);
    int cold_lo = 0, tail = 0, n_stb = 0, stb_idx = -1, rise_idx = -1, bad = 0, gate_bad = 0;
    for (int j = 0; j < off; j++) begin
      @(posedge clk); #1; pwr_good = 1'b0; warm_req = 1'b0;
      @(negedge clk);
      if (cold_n || warm_n || done) gate_bad++;
    end
    chk(gate_bad == 0, "R9 outputs low while power off", gate_bad, 0);
    for (int i = 0; i < C + W + 12; i++) begin
      @(posedge clk); #1;
      pwr_good = 1'b1;
      warm_req = (req_len > 0) && (i >= req_at) && (i < req_at + req_len);
      @(negedge clk);
      if (!cold_n) cold_lo++;
      if (cold_n && !warm_n) tail++;
      if (stb) begin n_stb++; stb_idx = i; end
      if (cold_n && rise_idx < 0) rise_idx = i;
      if ((done && !(cold_n && warm_n)) || (warm_n && !cold_n)) bad++;
    end
    warm_req = 1'b0;
    chk(cold_lo == C + 2, "R2 cold hold length", cold_lo, C + 2);
    chk(tail == W, "R3/R8 warm tail length", tail, W);
    chk(n_stb == 1, "R4 strobe count", n_stb, 1);
    chk(rise_idx - stb_idx == L, "R4 strobe lead", rise_idx - stb_idx, L);
    chk(bad == 0 && done, "R5 done and ordering", bad, 0);
  endtask

  task automatic warm_only(input int hold, input string tag);
    int lo = 0, first = -1, falls = 0, cold_lo = 0, n_stb = 0;
    logic prev = 1'b1;
    for (int i = 0; i < hold + W + 10; i++) begin
      @(posedge clk); #1; warm_req = (i < hold);
      @(negedge clk);
      if (!warm_n) begin lo++; if (first < 0) first = i; end
      if (prev && !warm_n) falls++;
      prev = warm_n;
      if (!cold_n) cold_lo++;
      if (stb) n_stb++;
    end
    warm_req = 1'b0;
    chk(lo == W, {tag, " warm-only length"}, lo, W);
    chk(first == 3, "R6 warm-only latency", first, 3);
    chk(falls == 1, "R7 single pulse", falls, 1);
    chk(cold_lo == 0 && n_stb == 0, "R6 cold and strobe quiet", cold_lo + n_stb, 0);
    chk(done == 1'b1, "R5 done after warm-only", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cold_n && !warm_n && !stb && !done, "R1 reset state",
        {28'd0, cold_n, warm_n, stb, done}, 0);
    @(posedge clk); #1; pwr_good = 1'b0;
    @(posedge clk); #1; rst_ni = 1'b1;

    for (int v = 0; v < NV; v++)
      run_seq(int'(VECS[v][47:32]), int'(VECS[v][31:16]), int'(VECS[v][15:0]));

    warm_only(2, "R6");
    warm_only(3 * W, "R7");

    // R9: immediate gating during run
    @(posedge clk); #1; pwr_good = 1'b0; #1;
    chk(!cold_n && !warm_n && !done, "R9 immediate gating",
        {29'd0, cold_n, warm_n, done}, 0);
    run_seq(3, 0, 0);

    // R9: drop in mid-sequence, then full restart
    @(posedge clk); #1; pwr_good = 1'b0;
    @(posedge clk); #1; pwr_good = 1'b1;
    repeat (20) @(posedge clk);
    run_seq(2, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule